// File: doc/BRIEF.md
# Fractional-Step Nanosecond Time Counter

This block keeps a free-running time of day for precision time stamping. The time is held in an accumulator with two parts: a 64-bit whole-nanosecond count and a 32-bit fraction of a nanosecond. While counting is on, a programmable step is added to the accumulator on every clock cycle. The step is a 32.32 fixed-point nanosecond value, so software can trim the rate of the time base without touching the clock source. The nominal step is (10^9 * 2^32) / f_clk. For example, at 800 MHz the step is 1.25 ns, written as 0x0000_0001_4000_0000.

Software reaches the block through a plain 64-bit register bus. The bus has an address, a write strobe with write data, and a read strobe. Read data is registered. Software enables or disables counting, programs the step and reads the fraction or the whole-nanosecond count. Each read returns a single-cycle snapshot.

Top module: `tod_timer`

## Requirements
- R1: After reset, the control register, the step register, the nanosecond count and the fraction all read as zero.
- R2: While enabled, the 96-bit value {nanoseconds, fraction} grows by the zero-extended 64-bit step on every clock cycle. Any carry out of the 32-bit fraction adds into the nanosecond count, which wraps modulo 2^64.
- R3: The control register is at offset 0xF00. Bit 0 is the count enable and the other bits read as zero. While bit 0 is clear, the nanosecond count and the fraction hold their values.
- R4: The step register is at offset 0xF18 and can be read and written as 64 bits. Bits 63:32 are whole nanoseconds and bits 31:0 are the fraction. A write made in one cycle is used by the additions from the next cycle onward.
- R5: A read at offset 0xF10 returns the whole-nanosecond count as it stood at the clock edge that sampled the read strobe.
- R6: A read at offset 0xF08 returns the fraction in bits 31:0 and zero in bits 63:32.
- R7: Any offset other than the four above reads as zero. A write to such an offset, or to the read-only offsets 0xF08 and 0xF10, changes neither the registers nor the time.
- R8: Read data appears one cycle after the read strobe. Read data is zero in any cycle that follows a cycle without a read strobe.
- R9: With a step that has a fraction only (0x0000_0000_8000_0000), the nanosecond count advances by one every two enabled cycles, through carries alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 64 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 64 | Registered read data |

## Verification
A wrong accumulator state never stays hidden. Each wrong value shows up at the next read of 0xF08 or 0xF10, exactly one cycle after the strobe. A bad carry into the nanoseconds, or a bad hold while disabled, shows up within two cycles as a mismatch against a bench model that repeats the addition rule each cycle. A decode fault shows up in the same cycle as a nonzero value from an unmapped offset or as a changed step read-back. Idle read data is also checked every cycle for zero.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int unsigned OFS_W = 12;
  localparam logic [OFS_W-1:0] OFS_CTRL = 12'hF00;
  localparam logic [OFS_W-1:0] OFS_FRAC = 12'hF08;
  localparam logic [OFS_W-1:0] OFS_NSEC = 12'hF10;
  localparam logic [OFS_W-1:0] OFS_STEP = 12'hF18;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_FRAC,
    SEL_NSEC,
    SEL_STEP
  } reg_sel_e;

  function automatic reg_sel_e sel_of(input logic [OFS_W-1:0] ofs);
    unique case (ofs)
      OFS_CTRL: sel_of = SEL_CTRL;
      OFS_FRAC: sel_of = SEL_FRAC;
      OFS_NSEC: sel_of = SEL_NSEC;
      OFS_STEP: sel_of = SEL_STEP;
      default:  sel_of = SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/tod_decode.sv
module tod_decode
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  logic hi_zero;

  generate
    if (ADDR_W > OFS_W) begin : g_wide
      assign hi_zero = (addr_i[ADDR_W-1:OFS_W] == '0);
    end else begin : g_exact
      assign hi_zero = 1'b1;
    end
  endgenerate

  always_comb begin
    sel_o = SEL_NONE;
    if (hi_zero) sel_o = sel_of(addr_i[OFS_W-1:0]);
  end
endmodule

// File: rtl/tod_ctrl_regs.sv
module tod_ctrl_regs
  import tod_pkg::*;
#(
  parameter int unsigned STEP_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [63:0]       wdata_i,
  output logic              en_o,
  output logic [STEP_W-1:0] step_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      step_o <= '0;
    end else if (wr_i) begin
      if (sel_i == SEL_CTRL) en_o <= wdata_i[0];
      if (sel_i == SEL_STEP) step_o <= wdata_i[STEP_W-1:0];
    end
  end
endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int unsigned NS_W   = 64,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned STEP_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [NS_W-1:0]   ns_o,
  output logic [FRAC_W-1:0] frac_o
);
  localparam int unsigned STEP_INT_W = STEP_W - FRAC_W;

  logic [FRAC_W:0]   frac_sum;
  logic [NS_W-1:0]   ns_sum;

  // fraction first; its carry feeds the whole-ns adder
  assign frac_sum = {1'b0, frac_o} + {1'b0, step_i[FRAC_W-1:0]};
  assign ns_sum   = ns_o + NS_W'(step_i[STEP_W-1:FRAC_W]) + NS_W'(frac_sum[FRAC_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_o   <= '0;
      frac_o <= '0;
    end else if (en_i) begin
      ns_o   <= ns_sum;
      frac_o <= frac_sum[FRAC_W-1:0];
    end
  end

  logic unused_w;
  assign unused_w = ^STEP_INT_W;
endmodule

// File: rtl/tod_rdata.sv
module tod_rdata
  import tod_pkg::*;
#(
  parameter int unsigned NS_W   = 64,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned STEP_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  reg_sel_e          sel_i,
  input  logic              en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [NS_W-1:0]   ns_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [63:0]       rdata_o
);
  logic [63:0] mux_d;

  always_comb begin
    mux_d = '0;
    if (rd_i) begin
      unique case (sel_i)
        SEL_CTRL: mux_d = {63'd0, en_i};
        SEL_FRAC: mux_d = 64'(frac_i);
        SEL_NSEC: mux_d = 64'(ns_i);
        SEL_STEP: mux_d = 64'(step_i);
        default:  mux_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= mux_d;
  end
endmodule

// File: rtl/tod_timer.sv
module tod_timer
  import tod_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NS_W   = 64,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned STEP_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [63:0]       wdata_i,
  input  logic              rd_i,
  output logic [63:0]       rdata_o
);
  reg_sel_e          sel_w;
  logic              en_w;
  logic [STEP_W-1:0] step_w;
  logic [NS_W-1:0]   ns_w;
  logic [FRAC_W-1:0] frac_w;

  tod_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (addr_i),
    .sel_o  (sel_w)
  );

  tod_ctrl_regs #(.STEP_W(STEP_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .sel_i   (sel_w),
    .wdata_i (wdata_i),
    .en_o    (en_w),
    .step_o  (step_w)
  );

  tod_accum #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .step_i (step_w),
    .ns_o   (ns_w),
    .frac_o (frac_w)
  );

  tod_rdata #(.NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_rdata (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .sel_i   (sel_w),
    .en_i    (en_w),
    .step_i  (step_w),
    .ns_i    (ns_w),
    .frac_i  (frac_w),
    .rdata_o (rdata_o)
  );
endmodule

// File: rtl/tod_timer_chk.sv
module tod_timer_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned NS_W   = 64,
  parameter int unsigned FRAC_W = 32,
  parameter int unsigned STEP_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_i,
  input logic [63:0]       wdata_i,
  input logic              rd_i,
  input logic [63:0]       rdata_o,
  input logic              en_q,
  input logic [STEP_W-1:0] step_q,
  input logic [NS_W-1:0]   ns_q,
  input logic [FRAC_W-1:0] frac_q
);
  localparam int unsigned ACC_W = NS_W + FRAC_W;

  logic is_ctrl, is_frac, is_nsec, is_step, mapped;
  assign is_ctrl = (addr_i == ADDR_W'(12'hF00));
  assign is_frac = (addr_i == ADDR_W'(12'hF08));
  assign is_nsec = (addr_i == ADDR_W'(12'hF10));
  assign is_step = (addr_i == ADDR_W'(12'hF18));
  assign mapped  = is_ctrl | is_frac | is_nsec | is_step;

  assert_advance_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> {ns_q, frac_q} == $past({ns_q, frac_q}) + ACC_W'($past(step_q)));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> $stable(ns_q) && $stable(frac_q));

  assert_step_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && is_step) |=> step_q == $past(wdata_i[STEP_W-1:0]));

  assert_ns_read_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && is_nsec) |=> rdata_o == 64'($past(ns_q)));

  assert_unmapped_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !mapped) |=> rdata_o == '0);

  assert_unmapped_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !is_ctrl && !is_step) |=> $stable(step_q) && $stable(en_q));

  assert_idle_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0);
endmodule

bind tod_timer tod_timer_chk #(
  .ADDR_W(ADDR_W), .NS_W(NS_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .wr_i    (wr_i),
  .wdata_i (wdata_i),
  .rd_i    (rd_i),
  .rdata_o (rdata_o),
  .en_q    (en_w),
  .step_q  (step_w),
  .ns_q    (ns_w),
  .frac_q  (frac_w)
);

// File: tb/tod_timer_bench.sv
`timescale 1ns/1ps
module tod_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0;
  logic [63:0] wdata = '0;
  logic        rd = 1'b0;
  logic [63:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tod_timer u_tod_timer (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wr_i (wr),
    .wdata_i (wdata), .rd_i (rd), .rdata_o (rdata)
  );

  // reference model built from the requirements
  logic [95:0] m_acc;
  logic        m_en;
  logic [63:0] m_step;
  string       cur_tag = "R1";
  logic [63:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [63:0] model_read(input logic [11:0] a);
    case (a)
      12'hF00: return {63'd0, m_en};
      12'hF08: return {32'd0, m_acc[31:0]};
      12'hF10: return m_acc[95:32];
      12'hF18: return m_step;
      default: return 64'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = '0; m_en = 1'b0; m_step = '0;
    end else begin
      if (rd) begin
        exp_q.push_back(model_read(addr));
        tag_q.push_back(cur_tag);
      end
      if (m_en) m_acc = m_acc + {32'd0, m_step};
      if (wr) begin
        if (addr == 12'hF00) m_en = wdata[0];
        if (addr == 12'hF18) m_step = wdata;
      end
    end
  end

  // monitor: read data due one cycle after the strobe, zero otherwise (R8)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [63:0] e;
      string t;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
      end else begin
        e = 64'd0;
        t = "R8";
      end
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr = 1'b0; rd = 1'b0;
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1; rd = 1'b0;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, input string tag);
    @(negedge clk);
    addr = a; rd = 1'b1; wr = 1'b0; cur_tag = tag;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // direct check of a value that needs no model
  task automatic expect_direct(input logic [11:0] a, input logic [63:0] e, input string tag);
    logic [63:0] got;
    @(negedge clk);
    addr = a; rd = 1'b1; cur_tag = tag;
    @(negedge clk);
    rd = 1'b0;
    got = rdata;
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s: direct actual=%h expected=%h", tag, got, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_direct(12'hF00, 64'd0, "R1");
    expect_direct(12'hF18, 64'd0, "R1");
    expect_direct(12'hF10, 64'd0, "R1");
    expect_direct(12'hF08, 64'd0, "R1");
    idle(3);
    expect_direct(12'hF10, 64'd0, "R3");

    // R4 step write and read-back, 1.25 ns
    wr_reg(12'hF18, 64'h0000_0001_4000_0000);
    expect_direct(12'hF18, 64'h0000_0001_4000_0000, "R4");
    // R3 only bit 0 kept
    wr_reg(12'hF00, 64'hFFFF_0000_0000_0003);
    expect_direct(12'hF00, 64'd1, "R3");
    idle(5);
    rd_reg(12'hF10, "R5");
    rd_reg(12'hF08, "R6");
    rd_reg(12'hF10, "R2");
    // back-to-back reads of both parts
    @(negedge clk); addr = 12'hF10; rd = 1'b1; cur_tag = "R5";
    @(negedge clk); addr = 12'hF08; cur_tag = "R6";
    @(negedge clk); rd = 1'b0;

    // R4 step change while running
    wr_reg(12'hF18, 64'h0000_0003_0000_0007);
    idle(4);
    rd_reg(12'hF10, "R4");
    rd_reg(12'hF08, "R4");

    // R3 disable holds time
    wr_reg(12'hF00, 64'd0);
    rd_reg(12'hF10, "R3");
    idle(10);
    rd_reg(12'hF10, "R3");
    rd_reg(12'hF08, "R3");

    // R7 unmapped and read-only offsets
    wr_reg(12'hF20, 64'hDEAD_BEEF_0000_0001);
    wr_reg(12'hF10, 64'h1234_5678_9ABC_DEF0);
    wr_reg(12'hF08, 64'hFFFF_FFFF_FFFF_FFFF);
    wr_reg(12'hF01, 64'h1);
    expect_direct(12'hF00, 64'd0, "R7");
    expect_direct(12'hF18, 64'h0000_0003_0000_0007, "R7");
    rd_reg(12'hF10, "R7");
    rd_reg(12'hF08, "R7");
    expect_direct(12'hF20, 64'd0, "R7");
    expect_direct(12'h000, 64'd0, "R7");
    expect_direct(12'hF1C, 64'd0, "R7");

    // R9 fraction-only step: carries alone move the ns count
    wr_reg(12'hF18, 64'h0000_0000_8000_0000);
    wr_reg(12'hF00, 64'd1);
    for (int i = 0; i < 6; i++) rd_reg(12'hF10, "R9");
    rd_reg(12'hF08, "R9");

    // R2 carry with odd fraction, enable written while reading
    wr_reg(12'hF18, 64'h0000_0002_FFFF_FFFF);
    idle(7);
    rd_reg(12'hF10, "R2");
    rd_reg(12'hF08, "R2");
    @(negedge clk); addr = 12'hF10; rd = 1'b1; cur_tag = "R2";
    @(negedge clk); addr = 12'hF00; wr = 1'b1; wdata = 64'd0; cur_tag = "R3";
    @(negedge clk); rd = 1'b0; wr = 1'b0;
    idle(4);
    rd_reg(12'hF10, "R3");
    idle(3);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    done = 1'b1;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule